// File: doc/BRIEF.md
# Hot-plug slot event status logic

This block holds the event flags and masks for a single hot-plug slot. It watches four level inputs from the slot (power fault, retention latch sensor, attention button, card presence) together with the slot's two-bit state. When a defined transition is seen, it sets a sticky status flag. Software clears a flag by writing 1 to its bit.

The flags are combined with per-event masks and two global masks. The result drives an interrupt request and a system error request. A power fault is sorted into one of two flags, depending on whether the slot is enabled at the moment the fault rises. Only the connected power fault and the latch sensor change can raise a system error.

Software reaches the block through a small register port. Writes take effect at the clock edge and reads are combinational. Address 0 is the status register and address 1 is the mask register.

Top module: `hp_slot_evt`

## Requirements
- R1: After reset, every status bit is 0, the mask register reads 0x1FF (every event and both outputs masked), and `irq_req` and `serr_req` are 0.
- R2: Status bit 0 (connected power fault) sets when `pwr_fault` goes from 0 to 1 while `slot_state` is 2'b10. A falling `pwr_fault` sets nothing.
- R3: Status bit 1 (isolated power fault) sets when `pwr_fault` goes from 0 to 1 while `slot_state` is any value other than 2'b10.
- R4: Status bit 2 (latch change) sets on every change of `latch_open`, in either direction.
- R5: Status bit 3 (button) sets only when `button` goes from 0 to 1. A falling edge leaves it alone.
- R6: Status bit 4 (card change) sets on every change of `card_present`, in either direction.
- R7: Writing to address 0 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R8: If an event sets a status bit in the same cycle that a write clears it, the bit ends at 1.
- R9: `irq_req` is 1 exactly when some status bit is 1, its interrupt mask bit is 0, and the global interrupt mask is 0. Mask register bits 4:0 are the per-event interrupt masks in status-bit order, and bit 7 is the global interrupt mask.
- R10: `serr_req` is 1 exactly when the global error mask (mask bit 8) is 0 and one of two conditions holds: status bit 0 is set with mask bit 5 clear, or status bit 2 is set with mask bit 6 clear. Isolated-fault, button and card events never raise it.
- R11: Address 1 reads back the last value written to mask bits 8:0, with upper bits reading 0. Addresses 2 and 3 read 0, and writes to them change nothing.
- R12: No event is detected on the first clock after reset is released, whatever level the inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fault | input | 1 | Slot power fault level |
| latch_open | input | 1 | Retention latch sensor level |
| button | input | 1 | Attention button level |
| card_present | input | 1 | Card presence level |
| slot_state | input | 2 | Slot state, 2'b10 = enabled |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request |
| serr_req | output | 1 | System error request |

## Verification
The checker runs on every cycle. It watches four things:
- that a qualifying power-fault rise lands in the flag chosen by the slot state;
- that latch and card changes always set their flags;
- that a falling button edge never sets one;
- that the global masks silence their outputs and that a system error only ever comes with a fault or latch flag.

The reset values and the quiet first cycle after reset are also checked on every cycle. Some behaviour can only be shown by the bench's scenarios:
- the exact status pattern left by combined input changes;
- write-1-clear with zero bits left alone;
- the set-beats-clear collision;
- the mask read-back.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;

    localparam int NUM_EVT = 5;
    localparam int NUM_PIN = 4;

    localparam int EV_CPF   = 0;
    localparam int EV_IPF   = 1;
    localparam int EV_LATCH = 2;
    localparam int EV_BTN   = 3;
    localparam int EV_CARD  = 4;

    localparam logic [1:0] SLOT_ON = 2'b10;

    localparam int STS_ADDR  = 0;
    localparam int MASK_ADDR = 1;

    typedef struct packed {
        logic card;
        logic btn;
        logic latch;
        logic pf;
    } pins_t;

    typedef struct packed {
        logic               gerr;
        logic               girq;
        logic [1:0]         err;   // [1] latch, [0] connected fault
        logic [NUM_EVT-1:0] irq;
    } mask_t;

    localparam int    MASK_W   = $bits(mask_t);
    localparam mask_t MASK_RST = '1;

    function automatic logic [NUM_EVT-1:0] evt_set(pins_t rise, pins_t chg, logic [1:0] st);
        logic [NUM_EVT-1:0] s;
        s           = '0;
        s[EV_CPF]   = rise.pf && (st == SLOT_ON);
        s[EV_IPF]   = rise.pf && (st != SLOT_ON);
        s[EV_LATCH] = chg.latch;
        s[EV_BTN]   = rise.btn;
        s[EV_CARD]  = chg.card;
        return s;
    endfunction

endpackage

// File: rtl/hp_evt_edge.sv
module hp_evt_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev_q;
    logic         primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= sig;
            primed_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = primed_q & sig[i] & ~prev_q[i];
        assign chg[i]  = primed_q & (sig[i] ^ prev_q[i]);
    end
endmodule

// File: rtl/hp_evt_status.sv
module hp_evt_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] sts
);
    always_ff @(posedge clk) begin
        if (rst) sts <= '0;
        else     sts <= (sts & ~clr) | set;
    end
endmodule

// File: rtl/hp_evt_mask.sv
module hp_evt_mask
    import hp_evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  mask_t wdata,
    output mask_t mask
);
    always_ff @(posedge clk) begin
        if (rst)     mask <= MASK_RST;
        else if (we) mask <= wdata;
    end
endmodule

// File: rtl/hp_evt_out.sv
module hp_evt_out
    import hp_evt_pkg::*;
(
    input  logic [NUM_EVT-1:0] sts,
    input  mask_t              mask,
    output logic               irq,
    output logic               serr
);
    logic [1:0] err_src;

    always_comb begin
        irq     = (|(sts & ~mask.irq)) & ~mask.girq;
        err_src = {sts[EV_LATCH] & ~mask.err[1], sts[EV_CPF] & ~mask.err[0]};
        serr    = (|err_src) & ~mask.gerr;
    end
endmodule

// File: rtl/hp_slot_evt.sv
module hp_slot_evt
    import hp_evt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_fault,
    input  logic              latch_open,
    input  logic              button,
    input  logic              card_present,
    input  logic [1:0]        slot_state,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic              serr_req
);
    pins_t              pins_now;
    logic [NUM_PIN-1:0] rise_v, chg_v;
    logic [NUM_EVT-1:0] set_v, clr_v, sts_q;
    mask_t              mask_q;
    logic               sel_sts, sel_mask;
    logic               unused_wdata;

    assign pins_now.pf    = pwr_fault;
    assign pins_now.latch = latch_open;
    assign pins_now.btn   = button;
    assign pins_now.card  = card_present;

    assign sel_sts  = (reg_addr == ADDR_W'(STS_ADDR));
    assign sel_mask = (reg_addr == ADDR_W'(MASK_ADDR));

    hp_evt_edge #(.W(NUM_PIN)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (pins_now),
        .rise (rise_v),
        .chg  (chg_v)
    );

    assign set_v = evt_set(pins_t'(rise_v), pins_t'(chg_v), slot_state);
    assign clr_v = (reg_we && sel_sts) ? reg_wdata[NUM_EVT-1:0] : '0;

    hp_evt_status #(.N(NUM_EVT)) u_sts (
        .clk (clk),
        .rst (rst),
        .set (set_v),
        .clr (clr_v),
        .sts (sts_q)
    );

    hp_evt_mask u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we && sel_mask),
        .wdata (mask_t'(reg_wdata[MASK_W-1:0])),
        .mask  (mask_q)
    );

    hp_evt_out u_out (
        .sts  (sts_q),
        .mask (mask_q),
        .irq  (irq_req),
        .serr (serr_req)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_sts)       reg_rdata[NUM_EVT-1:0] = sts_q;
        else if (sel_mask) reg_rdata[MASK_W-1:0]  = mask_q;
    end

    assign unused_wdata = ^reg_wdata[DATA_W-1:MASK_W];
endmodule

// File: rtl/hp_slot_evt_chk.sv
module hp_slot_evt_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_fault,
    input logic       latch_open,
    input logic       button,
    input logic       card_present,
    input logic [1:0] slot_state,
    input logic [4:0] sts,
    input logic [8:0] mask,
    input logic       irq_req,
    input logic       serr_req
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sts == 5'd0 && mask == 9'h1FF && !irq_req && !serr_req));

    // R2
    a_r2_cpf_set: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pwr_fault && !$past(pwr_fault) && slot_state == 2'b10) |=> sts[0]);

    // R3
    a_r3_ipf_set: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pwr_fault && !$past(pwr_fault) && slot_state != 2'b10) |=> sts[1]);

    // R4
    a_r4_latch_set: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && latch_open != $past(latch_open)) |=> sts[2]);

    // R5
    a_r5_btn_fall_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !button && $past(button) && !sts[3]) |=> !sts[3]);

    // R6
    a_r6_card_set: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && card_present != $past(card_present)) |=> sts[4]);

    // R9
    a_r9_global_irq_mask: assert property (@(posedge clk) disable iff (rst)
        mask[7] |-> !irq_req);

    // R10
    a_r10_serr_source: assert property (@(posedge clk) disable iff (rst)
        serr_req |-> (sts[0] || sts[2]));

    // R10
    a_r10_global_serr_mask: assert property (@(posedge clk) disable iff (rst)
        mask[8] |-> !serr_req);

    // R12
    a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |=> (sts == 5'd0));
endmodule

bind hp_slot_evt hp_slot_evt_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_fault    (pwr_fault),
    .latch_open   (latch_open),
    .button       (button),
    .card_present (card_present),
    .slot_state   (slot_state),
    .sts          (sts_q),
    .mask         (mask_q),
    .irq_req      (irq_req),
    .serr_req     (serr_req)
);

// File: tb/sim_hp_slot_evt.sv
`timescale 1ns/1ps
module sim_hp_slot_evt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_fault = 1'b0, latch_open = 1'b0, button = 1'b0, card_present = 1'b0;
    logic [1:0]  slot_state = 2'b00;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req, serr_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hp_slot_evt u0 (
        .clk(clk), .rst(rst), .pwr_fault(pwr_fault), .latch_open(latch_open),
        .button(button), .card_present(card_present), .slot_state(slot_state),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .serr_req(serr_req)
    );

    // {pf, latch, btn, card, state[1:0], expected status[4:0]}
    localparam logic [10:0] VEC [12] = '{
        11'b1_0_0_0_10_00001,  // R2 fault while enabled
        11'b0_0_0_0_10_00000,  // R2 falling fault: nothing
        11'b1_0_0_0_01_00010,  // R3 fault while not enabled
        11'b0_1_0_0_01_00100,  // R4 latch rise
        11'b0_0_0_0_01_00100,  // R4 latch fall
        11'b0_0_1_0_01_01000,  // R5 button press
        11'b0_0_0_0_01_00000,  // R5 button release: nothing
        11'b0_0_0_1_01_10000,  // R6 card in
        11'b0_0_0_0_01_10000,  // R6 card out
        11'b1_1_1_1_10_11101,  // R2 R4 R5 R6 together
        11'b0_0_0_0_11_10100,  // R4 R6 falls, state 11
        11'b1_0_0_0_00_00010   // R3 state 00
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
        reg_addr = 2'd0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0x1 expected 0x0");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(); step();

        // R1 reset state
        rd(2'd0, d); check("R1 status", d, 32'h0);
        rd(2'd1, d); check("R1 mask", d, 32'h1FF);
        check("R1 irq", {31'd0, irq_req}, 32'h0);
        check("R1 serr", {31'd0, serr_req}, 32'h0);

        // R11 mask access and unused addresses
        wr(2'd1, 32'h0AA);       rd(2'd1, d); check("R11 mask readback", d, 32'h0AA);
        wr(2'd1, 32'hFFFF_FE00); rd(2'd1, d); check("R11 mask upper bits", d, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); check("R11 addr 2 reads 0", d, 32'h0);
        rd(2'd1, d); check("R11 addr 2 write ignored", d, 32'h0);

        // table walk
        for (int i = 0; i < 12; i++) begin
            {pwr_fault, latch_open, button, card_present, slot_state} = VEC[i][10:5];
            step();
            rd(2'd0, d);
            check($sformatf("R2-6 vector %0d", i), d, {27'd0, VEC[i][4:0]});
            wr(2'd0, 32'h1F);
        end
        pwr_fault = 1'b0; slot_state = 2'b00;
        step(); wr(2'd0, 32'h1F);

        // R9 interrupt masking
        button = 1'b1; step();
        check("R9 irq unmasked", {31'd0, irq_req}, 32'h1);
        check("R10 button no serr", {31'd0, serr_req}, 32'h0);
        wr(2'd1, 32'h008);
        check("R9 per-event mask", {31'd0, irq_req}, 32'h0);
        wr(2'd1, 32'h080);
        check("R9 global irq mask", {31'd0, irq_req}, 32'h0);
        wr(2'd1, 32'h000);
        check("R9 irq unmasked again", {31'd0, irq_req}, 32'h1);
        wr(2'd0, 32'h1F);
        check("R9 irq after clear", {31'd0, irq_req}, 32'h0);
        button = 1'b0; step();

        // R10 system error
        latch_open = 1'b1; step();
        check("R10 latch serr", {31'd0, serr_req}, 32'h1);
        wr(2'd1, 32'h040);
        check("R10 latch err mask", {31'd0, serr_req}, 32'h0);
        check("R10 irq still on", {31'd0, irq_req}, 32'h1);
        wr(2'd1, 32'h100);
        check("R10 global err mask", {31'd0, serr_req}, 32'h0);
        wr(2'd1, 32'h000); wr(2'd0, 32'h1F);
        slot_state = 2'b10; pwr_fault = 1'b1; step();
        check("R10 cpf serr", {31'd0, serr_req}, 32'h1);
        wr(2'd1, 32'h020);
        check("R10 cpf err mask", {31'd0, serr_req}, 32'h0);
        wr(2'd1, 32'h000); wr(2'd0, 32'h1F);
        pwr_fault = 1'b0; step();
        slot_state = 2'b00; pwr_fault = 1'b1; step();
        check("R10 ipf no serr", {31'd0, serr_req}, 32'h0);
        check("R10 ipf irq", {31'd0, irq_req}, 32'h1);
        wr(2'd0, 32'h1F);
        pwr_fault = 1'b0; step();

        // R7 write-1-clear
        button = 1'b1; latch_open = 1'b0; step();
        rd(2'd0, d); check("R7 setup", d, 32'h0C);
        wr(2'd0, 32'h0); rd(2'd0, d); check("R7 write 0 keeps", d, 32'h0C);
        wr(2'd0, 32'h04); rd(2'd0, d); check("R7 clear one bit", d, 32'h08);
        wr(2'd0, 32'h08); rd(2'd0, d); check("R7 clear last", d, 32'h0);

        // R8 set beats clear
        slot_state = 2'b10; pwr_fault = 1'b1;
        wr(2'd0, 32'h01);
        rd(2'd0, d); check("R8 set wins", d, 32'h01);
        wr(2'd0, 32'h1F);

        // R12 no detection right after reset
        rst = 1'b1;
        latch_open = 1'b1; card_present = 1'b1; pwr_fault = 1'b0; button = 1'b0;
        step(); step();
        pwr_fault = 1'b1; button = 1'b1;
        rst = 1'b0;
        step(); step();
        rd(2'd0, d); check("R12 quiet after reset", d, 32'h0);
        step();
        rd(2'd0, d); check("R12 still quiet", d, 32'h0);
        rd(2'd1, d); check("R1 mask after second reset", d, 32'h1FF);

        finish_run();
    end
endmodule